// File: doc/BRIEF.md
# Byte-Lane Word Memory

A single-ported memory that appears to its user as 256 locations of one byte each, while keeping its contents as 64 words of 32 bits. The user presents an 8-bit address. The upper six address bits pick a word, and the lower two bits pick one byte lane inside that word. Read data and write data travel on separate 8-bit ports.

The read port always shows the addressed byte. It has no enable and no clock latency. A write is requested by holding the write enable high together with the address and data for one cycle. At the next rising edge the block does a read-modify-write of the addressed word: the selected lane takes the new byte, and the other three lanes are written back with the values they already held. A synchronous active-low reset clears every word to zero, so tests can start from a known state and fill locations through the ordinary write port.

Top module: `bytemem_top`

## Requirements
- R1: All 256 byte addresses 0 to 255 are distinct storage locations. A byte written to one address is read back from that address and from no other.
- R2: Address bits [7:2] select one of 64 words. Address bits [1:0] select the byte lane: lane 0 is word bits [7:0], lane 1 is [15:8], lane 2 is [23:16] and lane 3 is [31:24].
- R3: rdData always equals the byte stored at the current addr, in the same cycle, with no read enable.
- R4: When wrEn is 1 at a rising clock edge, the byte on wrData is stored at addr, and it is visible on rdData right after that edge.
- R5: A write changes only the addressed lane. The other three bytes of the same word keep their values.
- R6: While a write to addr is pending in a cycle, rdData shows the old byte at that address until the clock edge has passed.
- R7: When wrEn is 0 no location changes, whatever values are on wrData and addr.
- R8: When rst_n is 0 at a rising edge, every location is cleared to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low clear of all contents |
| addr | input | 8 | Byte address: [7:2] word, [1:0] lane |
| wrData | input | 8 | Byte to store when wrEn is 1 |
| wrEn | input | 1 | Write request for the current cycle |
| rdData | output | 8 | Byte at addr, combinational |

## Verification
The read result is due in the same cycle as the address, so the bench changes addr on the falling edge and samples rdData 1 ns later. A write takes effect at the next rising edge. The bench therefore samples once before that edge, where the old byte is expected (R6), and again after the following falling edge, where the new byte is expected. The effect of a reset is checked after the first falling edge that follows the reset edge. Each check compares against a byte-array model in the bench, which is updated only at the edges where the write or the reset takes effect.

// File: rtl/bytemem_pkg.sv
package bytemem_pkg;
  parameter int unsigned BM_LANES = 4;
  localparam int unsigned BM_LANE_BITS = $clog2(BM_LANES);

  typedef struct packed {
    logic                wrStrobe;
    logic [BM_LANES-1:0] laneHit;
  } memCtrl_t;
endpackage

// File: rtl/bytemem_ctrl.sv
module bytemem_ctrl
  import bytemem_pkg::*;
(
  input  logic                    wrEn,
  input  logic [BM_LANE_BITS-1:0] laneIdx,
  output memCtrl_t                ctrlBus
);
  logic [BM_LANES-1:0] laneDec;

  for (genvar i = 0; i < BM_LANES; i++) begin : g_dec
    assign laneDec[i] = wrEn && (laneIdx == BM_LANE_BITS'(i));
  end

  always_comb begin
    ctrlBus.wrStrobe = wrEn;
    ctrlBus.laneHit  = laneDec;
  end
endmodule

// File: rtl/bytemem_dp.sv
module bytemem_dp
  import bytemem_pkg::*;
#(
  parameter int unsigned WORD_BITS = 6,
  parameter int unsigned BYTE_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WORD_BITS-1:0]    wordIdx,
  input  logic [BM_LANE_BITS-1:0] laneIdx,
  input  logic [BYTE_W-1:0]       wrData,
  input  memCtrl_t                ctrlBus,
  output logic [BYTE_W-1:0]       rdData
);
  localparam int unsigned DEPTH  = 2 ** WORD_BITS;
  localparam int unsigned WORD_W = BYTE_W * BM_LANES;

  logic [WORD_W-1:0] store [DEPTH];
  logic [WORD_W-1:0] curWord;
  logic [WORD_W-1:0] mergedWord;
  logic [BYTE_W-1:0] laneView [BM_LANES];

  assign curWord = store[wordIdx];

  for (genvar i = 0; i < BM_LANES; i++) begin : g_lane
    assign laneView[i] = curWord[i*BYTE_W +: BYTE_W];
    assign mergedWord[i*BYTE_W +: BYTE_W] =
      ctrlBus.laneHit[i] ? wrData : laneView[i];
  end

  assign rdData = laneView[laneIdx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) store[w] <= '0;
    end else if (ctrlBus.wrStrobe) begin
      store[wordIdx] <= mergedWord;
    end
  end
endmodule

// File: rtl/bytemem_top.sv
module bytemem_top
  import bytemem_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              wrEn,
  output logic [BYTE_W-1:0] rdData
);
  localparam int unsigned WORD_BITS = ADDR_W - BM_LANE_BITS;

  memCtrl_t ctrlBus;

  bytemem_ctrl ctrl_i (
    .wrEn    (wrEn),
    .laneIdx (addr[BM_LANE_BITS-1:0]),
    .ctrlBus (ctrlBus)
  );

  bytemem_dp #(.WORD_BITS(WORD_BITS), .BYTE_W(BYTE_W)) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wordIdx (addr[ADDR_W-1:BM_LANE_BITS]),
    .laneIdx (addr[BM_LANE_BITS-1:0]),
    .wrData  (wrData),
    .ctrlBus (ctrlBus),
    .rdData  (rdData)
  );
endmodule

// File: rtl/bytemem_chk.sv
module bytemem_chk
  import bytemem_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTE_W-1:0] wrData,
  input logic              wrEn,
  input logic [BYTE_W-1:0] rdData,
  input memCtrl_t          ctrlBus
);
  // R8: the first cycle out of reset reads zero at any address
  p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rdData == '0);

  // R4: the written byte is visible once the edge has passed
  p_write_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> (addr != $past(addr) || rdData == $past(wrData)));

  // R7: no write and the same address, so the read value holds
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wrEn) && $past(rst_n) && addr == $past(addr)) |-> $stable(rdData));

  // R5: a write strobes exactly one lane
  p_one_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlBus.wrStrobe |-> $countones(ctrlBus.laneHit) == 1);

  // R7: no lane is strobed without a write request
  p_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |-> (!ctrlBus.wrStrobe && ctrlBus.laneHit == '0));
endmodule

bind bytemem_top bytemem_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .wrData  (wrData),
  .wrEn    (wrEn),
  .rdData  (rdData),
  .ctrlBus (ctrlBus)
);

// File: tb/bytemem_tb_top.sv
`timescale 1ns/1ps
module bytemem_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0;
  logic [7:0] rdData;

  int testsRun = 0;
  int testsFailed = 0;
  logic [7:0] model [256];

  always #2.5 clk = ~clk;

  bytemem_top dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .wrData(wrData), .wrEn(wrEn), .rdData(rdData)
  );

  function automatic logic [7:0] expByte(input logic [7:0] a);
    return model[a];
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    testsRun++;
    if (rdData !== exp) begin
      testsFailed++;
      $display("FAIL %s addr=%02h actual=%02h expected=%02h", req, addr, rdData, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; wrEn = 1'b0;
    @(posedge clk);
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic doRead(input logic [7:0] a, input string req);
    @(negedge clk);
    addr = a; wrEn = 1'b0; wrData = 8'($urandom());
    #1 check(req, expByte(a));
  endtask

  // R6 check before the edge, then update the model at the edge
  task automatic doWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    #1 check("R6", expByte(a));
    @(posedge clk);
    model[a] = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h1234_5EED));
    for (int i = 0; i < 256; i++) model[i] = 8'hXX;
    doReset();
    // R8: reset state
    doRead(8'h00, "R8");
    doRead(8'hFF, "R8");
    doRead(8'h7A, "R8");
    // R4/R1: corner addresses
    doWrite(8'h00, 8'hA5); doRead(8'h00, "R4");
    doWrite(8'hFF, 8'h5A); doRead(8'hFF, "R1");
    doRead(8'h01, "R1"); doRead(8'hFE, "R1");
    // R5/R2: fill lanes of word 4, then overwrite lanes 0 and 3 only
    for (int l = 0; l < 4; l++) doWrite(8'h10 + 8'(l), 8'h11 * 8'(l + 1));
    doWrite(8'h10, 8'hC0);
    doWrite(8'h13, 8'hC3);
    for (int l = 0; l < 4; l++) doRead(8'h10 + 8'(l), "R5");
    doRead(8'h14, "R2"); doRead(8'h0F, "R2");
    // R6: back-to-back writes to one address
    doWrite(8'h40, 8'h01);
    doWrite(8'h40, 8'h02);
    doRead(8'h40, "R4");
    // R7: idle cycles with changing data leave contents alone
    for (int i = 0; i < 8; i++) doRead(8'h13, "R7");
    doRead(8'h10, "R7");
    // R3: address changes give the new byte in the same cycle
    doRead(8'h11, "R3"); doRead(8'h12, "R3"); doRead(8'h00, "R3");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      a = 8'($urandom());
      if ($urandom_range(0, 1) == 1) doWrite(a, 8'($urandom()));
      else doRead(a, "R1");
    end
    // R8: reset in the middle of a run
    doReset();
    doRead(8'h10, "R8"); doRead(8'hFF, "R8"); doRead(8'h40, "R8");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++; testsFailed++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule